// File: doc/BRIEF.md
# CSMA/CD Transmit Controller

This block is the transmit side of a media access controller for a shared medium with carrier sense. A client offers a frame length on a request port. Once the request is accepted, the controller waits until the carrier-sense input reports the medium idle. It then reads the frame from an external byte store, one byte per accepted cycle of a valid/ready output stream, addressed by a byte index that it drives.

While data bytes are going out, the controller watches a collision input. If a collision is seen, it drops the frame and drives a fixed four-byte jam burst so that every station notices the collision. It then waits a pseudo-random number of slot times and retries from the carrier-sense wait. After the sixteenth collision it gives up.

The controller signals each outcome with a one-cycle pulse: success, excess-collision abort, or a rejected length. It does not add a preamble or a check sequence, and it does no line coding.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After a request is accepted, and again after each backoff, the first data byte appears (`tx_valid`=1, `tx_jam`=0) in the cycle after the first clock edge at which `carrier_sense` is sampled low. It never appears earlier.
- R2: Data bytes are presented in index order 0 to len-1, with `tx_data` equal to the store byte at `rd_idx`. A byte stays presented, with the same index, until it is accepted with `tx_ready`=1. `tx_jam` is 0 on data bytes.
- R3: A collision sampled in any data cycle, including the cycle of the last byte, discards that byte even if `tx_ready` is 1. The next cycle presents the jam burst.
- R4: The jam burst is exactly 4 accepted bytes of 0xAA, each marked with `tx_jam`=1. The collision input has no effect while jamming.
- R5: After the n-th jam of a frame, `tx_valid` stays low for s*SLOT_CYCLES+2 cycles (the +2 being one cycle to close the wait and one to sense carrier on an idle medium). Here s is drawn from a free-running, never-zero 16-bit LFSR and lies in 0 to 2^k-1, with k = min(n,10).
- R6: Each retry restarts the frame from byte index 0.
- R7: When the last data byte is accepted without a collision, `done_ok` pulses for exactly one cycle in the next cycle, and the controller is idle (`req_ready`=1).
- R8: When the jam that follows the 16th collision completes, `done_abort` pulses for one cycle in the next cycle. No further bytes are sent and the controller is idle.
- R9: A request with a length of 0 or above MAX_LEN (1518) produces a one-cycle `len_err` pulse in the next cycle. Nothing is transmitted and the controller stays idle.
- R10: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R11: During and after reset, `req_ready`=1, `tx_valid`=0, and all three result pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request |
| req_len | input | 11 | Frame length in bytes |
| req_ready | output | 1 | Controller idle, request accepted |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| rd_idx | output | 11 | Index of the frame byte to present |
| rd_data | input | 8 | Frame byte at `rd_idx` |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Output byte accepted |
| tx_data | output | 8 | Output byte |
| tx_jam | output | 1 | Output byte belongs to the jam burst |
| done_ok | output | 1 | Frame sent pulse |
| done_abort | output | 1 | Excess-collision abort pulse |
| len_err | output | 1 | Rejected length pulse |

## Verification
The bench builds the controller with SLOT_CYCLES set to 2 and every other parameter at its default. With that setting, even the widest backoff window (1023 slots) lasts only about two thousand cycles. That makes a run of sixteen collisions ending in abort affordable, as well as a run of fifteen collisions followed by success. The 1518-byte maximum length stays in place, so both frame-length boundaries are exercised directly. Each measured backoff gap is checked against the slot multiple and the window allowed for that retry count.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_SEND,
    ST_JAM,
    ST_BACKOFF
  } tx_state_t;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign value = state_q;
endmodule

// File: rtl/csma_retry_ctr.sv
module csma_retry_ctr #(
  parameter int ATT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [ATT_W-1:0] count
);
  logic [ATT_W-1:0] cnt_q;
  logic [ATT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (bump) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/csma_backoff.sv
module csma_backoff #(
  parameter int CAP         = 10,
  parameter int SLOT_CYCLES = 64,
  parameter int EXP_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [CAP-1:0]   rnd,
  output logic             expired
);
  localparam int CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);

  logic [CAP-1:0]   mask;
  logic [CAP-1:0]   slots_q, slots_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  // window mask: bit i kept when the exponent exceeds i
  for (genvar i = 0; i < CAP; i++) begin : g_mask
    assign mask[i] = (exp_in > EXP_W'(i));
  end

  always_comb begin
    slots_d = slots_q;
    cyc_d   = cyc_q;
    if (load) begin
      slots_d = rnd & mask;
      cyc_d   = '0;
    end else if (slots_q != '0) begin
      if (cyc_q == CYC_LAST) begin
        cyc_d   = '0;
        slots_d = slots_q - 1'b1;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= '0;
      cyc_q   <= '0;
    end else begin
      slots_q <= slots_d;
      cyc_q   <= cyc_d;
    end
  end

  assign expired = (slots_q == '0);
endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
  import csma_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int          LEN_W        = 11,
  parameter int          MAX_LEN      = 1518,
  parameter int          JAM_LEN      = 4,
  parameter logic [7:0]  JAM_BYTE     = 8'hAA,
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          BACKOFF_CAP  = 10,
  parameter int          SLOT_CYCLES  = 64,
  parameter int          RND_W        = 16,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              carrier_sense,
  input  logic              collision,
  output logic [LEN_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_jam,
  output logic              done_ok,
  output logic              done_abort,
  output logic              len_err
);
  localparam int JAM_W = (JAM_LEN > 1) ? $clog2(JAM_LEN) : 1;
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int EXP_W = $clog2(BACKOFF_CAP + 1);
  localparam logic [JAM_W-1:0] JAM_LAST = JAM_W'(JAM_LEN - 1);
  localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_ATTEMPTS - 1);
  localparam logic [ATT_W-1:0] ATT_CAP  = ATT_W'(BACKOFF_CAP);

  tx_state_t        state_q, state_d;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [JAM_W-1:0] jam_q;
  logic             ok_q, abort_q, lenerr_q;

  logic             accept, len_bad, in_send, in_jam, in_defer;
  logic             last_byte, data_fire, frame_done, jam_fire, jam_done, give_up;
  logic [ATT_W-1:0] att_cnt, att_next;
  logic [EXP_W-1:0] bo_exp;
  logic             bo_load, bo_expired;
  logic [RND_W-1:0] rnd_w;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign len_bad    = (req_len == '0) || (req_len > LEN_W'(MAX_LEN));
  assign in_send    = (state_q == ST_SEND);
  assign in_jam     = (state_q == ST_JAM);
  assign in_defer   = (state_q == ST_DEFER);

  assign last_byte  = (idx_q == len_q - LEN_W'(1));
  assign data_fire  = in_send && !collision && tx_ready;
  assign frame_done = data_fire && last_byte;
  assign jam_fire   = in_jam && tx_ready;
  assign jam_done   = jam_fire && (jam_q == JAM_LAST);
  assign give_up    = (att_cnt == ATT_LAST);
  assign att_next   = att_cnt + 1'b1;
  assign bo_exp     = (att_next > ATT_CAP) ? EXP_W'(BACKOFF_CAP) : EXP_W'(att_next);
  assign bo_load    = jam_done && !give_up;

  assign tx_valid   = in_send || in_jam;
  assign tx_jam     = in_jam;
  assign tx_data    = in_jam ? JAM_BYTE[DATA_W-1:0] : rd_data;
  assign rd_idx     = idx_q;
  assign done_ok    = ok_q;
  assign done_abort = abort_q;
  assign len_err    = lenerr_q;

  csma_lfsr #(.W(RND_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd_w)
  );

  csma_retry_ctr #(.ATT_W(ATT_W)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .bump  (jam_done),
    .count (att_cnt)
  );

  csma_backoff #(
    .CAP         (BACKOFF_CAP),
    .SLOT_CYCLES (SLOT_CYCLES),
    .EXP_W       (EXP_W)
  ) u_backoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bo_load),
    .exp_in  (bo_exp),
    .rnd     (rnd_w[BACKOFF_CAP-1:0]),
    .expired (bo_expired)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (accept && !len_bad) state_d = ST_DEFER;
      ST_DEFER:   if (!carrier_sense)     state_d = ST_SEND;
      ST_SEND: begin
        if (collision)       state_d = ST_JAM;
        else if (frame_done) state_d = ST_IDLE;
      end
      ST_JAM:     if (jam_done) state_d = give_up ? ST_IDLE : ST_BACKOFF;
      ST_BACKOFF: if (bo_expired) state_d = ST_DEFER;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   len_q <= '0;
    else if (accept && !len_bad)  len_q <= req_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (in_defer)  idx_q <= '0;
    else if (data_fire) idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      jam_q <= '0;
    else if (in_send && collision)   jam_q <= '0;
    else if (jam_fire)               jam_q <= jam_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q     <= 1'b0;
      abort_q  <= 1'b0;
      lenerr_q <= 1'b0;
    end else begin
      ok_q     <= frame_done;
      abort_q  <= jam_done && give_up;
      lenerr_q <= accept && len_bad;
    end
  end
endmodule

// File: rtl/csma_tx_chk.sv
module csma_tx_chk #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 11,
  parameter int RND_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              carrier_sense,
  input logic              collision,
  input logic [LEN_W-1:0]  rd_idx,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_jam,
  input logic              done_ok,
  input logic              done_abort,
  input logic              len_err,
  input logic [RND_W-1:0]  rnd
);
  AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_jam && !$past(tx_valid)) |-> !$past(carrier_sense)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_jam && !tx_ready && !collision) |=> (tx_valid && !tx_jam && $stable(rd_idx))); // R2
  AST_COLL_TO_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_jam && collision) |=> (tx_valid && tx_jam)); // R3
  AST_JAM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_jam |-> (tx_valid && tx_data == 8'hAA)); // R4
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != '0); // R5
  AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !done_ok); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_abort |-> (req_ready && !tx_valid)); // R8
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_abort, len_err})); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid); // R10
endmodule

bind csma_tx_ctrl csma_tx_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W), .RND_W(RND_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .carrier_sense (carrier_sense),
  .collision     (collision),
  .rd_idx        (rd_idx),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .tx_jam        (tx_jam),
  .done_ok       (done_ok),
  .done_abort    (done_abort),
  .len_err       (len_err),
  .rnd           (rnd_w)
);

// File: tb/tb_csma_tx_ctrl.sv
module tb_csma_tx_ctrl;
  localparam int SLOT = 2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [10:0] req_len;
  logic        req_ready;
  logic        carrier_sense;
  logic        collision;
  logic [10:0] rd_idx;
  logic [7:0]  rd_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [7:0]  tx_data;
  logic        tx_jam;
  logic        done_ok;
  logic        done_abort;
  logic        len_err;

  int        checks = 0;
  int        errors = 0;
  bit        finished = 0;
  int        wd = 0;
  logic [7:0] salt = 8'h00;

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 13) ^ s;
  endfunction

  assign rd_data = pat(int'(rd_idx), salt);

  csma_tx_ctrl #(.SLOT_CYCLES(SLOT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .carrier_sense(carrier_sense), .collision(collision),
    .rd_idx(rd_idx), .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_jam(tx_jam), .done_ok(done_ok),
    .done_abort(done_abort), .len_err(len_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int min10(input int n);
    return (n > 10) ? 10 : n;
  endfunction

  task automatic run_frame(input int len, input int ncoll, input int cidx,
                           input int busy, input bit rnd_ready);
    int  exp_idx = 0, att = 0, jam_n = 0, gap = 0, cyc = 0, busy_left = busy;
    int  first_at = -1, bad_gap_val = 0;
    bit  gapping = 0, want_jam = 0, fin = 0;
    bit  data_bad = 0, jam_bad = 0, gap_bad = 0, coll_bad = 0, restart_bad = 0;
    bit  exp_ok = 0, exp_abort = 0, restarting = 0;
    bit  tv, tj, rdy, coll;
    salt = 8'($urandom);
    @(negedge clk);
    req_valid = 1'b1; req_len = 11'(len);
    carrier_sense = (busy_left > 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin && cyc < 60000) begin
      if (exp_ok || exp_abort) begin
        check(done_ok == exp_ok, "R7", "done_ok pulse", int'(done_ok), int'(exp_ok));
        check(done_abort == exp_abort, "R8", "done_abort pulse", int'(done_abort), int'(exp_abort));
        check(req_ready && !tx_valid, "R7", "idle after frame", int'(req_ready), 1);
        fin = 1;
      end else begin
        carrier_sense = (busy_left > 0);
        if (busy_left > 0) busy_left--;
        tv = tx_valid; tj = tx_jam;
        rdy = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
        tx_ready = rdy;
        coll = tv && !tj && (att < ncoll) && (exp_idx == cidx);
        collision = (tv && !tj) ? coll : 1'($urandom);
        #1;
        if (want_jam && !(tv && tj)) coll_bad = 1;
        want_jam = 0;
        if (tv && !tj) begin
          if (first_at < 0) first_at = cyc;
          if (gapping) begin
            if (gap < 2 || (gap - 2) % SLOT != 0 ||
                (gap - 2) / SLOT > (1 << min10(att)) - 1) begin
              gap_bad = 1; bad_gap_val = gap;
            end
            gapping = 0;
          end
          if (restarting && rd_idx != 0) restart_bad = 1;
          restarting = 0;
          if (tx_data != pat(exp_idx, salt)) data_bad = 1;
          if (coll) begin
            jam_n = 0; want_jam = 1;
          end else if (rdy) begin
            exp_idx++;
            if (exp_idx == len) exp_ok = 1;
          end
        end else if (tj) begin
          if (gapping || tx_data != 8'hAA) jam_bad = 1;
          if (rdy) begin
            jam_n++;
            if (jam_n == 4) begin
              att++; exp_idx = 0; restarting = 1;
              if (att == 16) exp_abort = 1;
              else begin gapping = 1; gap = 0; end
            end
          end
        end else if (gapping) gap++;
      end
      cyc++;
      @(negedge clk);
    end
    collision = 1'b0;
    check(fin, "R7", "frame completion", int'(fin), 1);
    check(first_at == busy + 1, "R1", "first data cycle after carrier", first_at, busy + 1);
    check(!data_bad, "R2", "data byte order/hold", int'(data_bad), 0);
    if (ncoll > 0) begin
      check(!coll_bad, "R3", "collision to jam", int'(coll_bad), 0);
      check(!jam_bad, "R4", "jam burst content/length", int'(jam_bad), 0);
      check(!gap_bad, "R5", "backoff gap", bad_gap_val, 2);
      check(!restart_bad, "R6", "restart from byte 0", int'(restart_bad), 0);
    end
  endtask

  task automatic bad_len(input int len);
    bit sent = 0;
    @(negedge clk);
    req_valid = 1'b1; req_len = 11'(len);
    @(negedge clk);
    req_valid = 1'b0;
    check(len_err == 1'b1, "R9", "len_err pulse", int'(len_err), 1);
    check(req_ready == 1'b1, "R10", "ready after reject", int'(req_ready), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_valid || len_err) sent = 1;
    end
    check(!sent, "R9", "nothing sent after reject", int'(sent), 0);
  endtask

  initial begin
    int l;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_len = '0; carrier_sense = 1'b0;
    collision = 1'b0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready && !tx_valid && !done_ok && !done_abort && !len_err,
          "R11", "reset outputs", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !tx_valid, "R11", "after reset release", int'(req_ready), 1);
    run_frame(1, 0, 0, 0, 1'b0);
    run_frame(5, 0, 0, 7, 1'b1);
    run_frame(1518, 0, 0, 2, 1'b1);
    run_frame(9, 1, 8, 0, 1'b0);
    run_frame(1, 3, 0, 1, 1'b1);
    bad_len(0);
    bad_len(1519);
    run_frame(6, 16, 2, 0, 1'b1);
    run_frame(3, 15, 1, 3, 1'b0);
    for (int n = 0; n < 20; n++) begin
      l = 1 + int'($urandom % 40);
      run_frame(l, int'($urandom % 5), int'($urandom % l), int'($urandom % 6), 1'b1);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule